// File: doc/BRIEF.md
# Multi-Slot Shared Countdown Timer

The block keeps sixteen countdown timers in one register bank. Software or a microcoded task programs a slot with a single 16-bit command word. The word carries a 4-bit state, an 8-bit count and the 4-bit number of the slot it targets. A separate opcode bit chooses between two commands. Overwrite replaces the remaining count. Accumulate adds the data to whatever count remains. Both commands also write the state. Every slot with a nonzero state counts down once per tick strobe.

When a slot runs out, its state drops to idle and its expiry becomes pending. A single wakeup line toward the service task stays high while any expiry is pending. The number of the highest pending slot is presented alongside it. The service task acknowledges expiries one at a time. The highest slot is meant for periodic memory refresh: the refresh handler re-arms it with an accumulate command after each expiry. Any slot can be inspected through a combinational read port.

Top module: `shared_timer_unit`

## Requirements
- R1: A synchronous reset clears the count and state of every slot and all pending expiries, so after reset the read port returns zero for every slot and `wake_req` is low.
- R2: An overwrite command (`cmd_op` = 0) sets the addressed slot's count to `cmd_word[11:4]` and its state to `cmd_word[15:12]`, where the slot is `cmd_word[3:0]`. The new values appear on the read port after that clock edge.
- R3: An accumulate command (`cmd_op` = 1) sets the addressed slot's count to the old count plus `cmd_word[11:4]`, modulo 256, and its state to `cmd_word[15:12]`.
- R4: On a clock edge with `tick` high, a slot whose state and count are both nonzero loses one count. A slot with state 0 keeps its count unchanged.
- R5: A slot expires on the tick that takes its count from 1 to 0 while its state is nonzero. Its state becomes 0, its expiry becomes pending, and `wake_req` is high from that clock edge on. `wake_req` never rises without an expiry.
- R6: While expiries are pending, `wake_slot` shows the highest-numbered pending slot, so slot 15, the refresh slot, is always served first.
- R7: `wake_ack` with `wake_req` high clears only the expiry shown on `wake_slot`. `wake_req` stays high while other expiries remain pending.
- R8: A command and a tick on the same edge for the same slot: the command result stands, that slot is not decremented, and it does not expire.
- R9: An expired slot stays at count 0 with state 0 and never expires again until it is written. Re-arming it with an accumulate command restarts the countdown from the added amount.
- R10: A slot with a nonzero state and a count of 0 neither counts nor expires.
- R11: `wake_ack` while no expiry is pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_op | input | 1 | 0 = overwrite count, 1 = add to remaining count |
| cmd_word | input | 16 | State [15:12], count data [11:4], slot [3:0] |
| tick | input | 1 | Countdown strobe for all active slots |
| wake_ack | input | 1 | Service task acknowledges the reported expiry |
| rd_slot | input | 4 | Slot selected on the read port |
| rd_state | output | 4 | State of the selected slot |
| rd_count | output | 8 | Remaining count of the selected slot |
| wake_req | output | 1 | High while any expiry is pending |
| wake_slot | output | 4 | Highest-numbered pending slot |

## Verification
Each command, tick and acknowledge takes effect at the clock edge on which it is presented. The read port follows the slot registers combinationally, so new contents are readable right after that edge. `wake_req` and `wake_slot` are driven from the pending register and change in the same cycle as the expiring tick or the acknowledge. The bench therefore drives each stimulus before a rising edge, steps its own reference model at that edge, and compares all outputs at the following falling edge. Read-port sweeps are completed with small sub-cycle steps before the next rising edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_CNT_W = 8;
    localparam int TMR_ST_W  = 4;

    typedef enum logic {
        OP_LOAD = 1'b0,
        OP_ADD  = 1'b1
    } tmr_op_e;

    typedef struct packed {
        logic [TMR_ST_W-1:0]  st;
        logic [TMR_CNT_W-1:0] cnt;
    } slot_t;
endpackage

// File: rtl/tmr_slot.sv
module tmr_slot
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  tmr_op_e              wr_op,
    input  logic [TMR_ST_W-1:0]  wr_st,
    input  logic [TMR_CNT_W-1:0] wr_cnt,
    output slot_t                slot_q,
    output logic                 expire
);
    slot_t slot_d;

    always_comb begin
        slot_d = slot_q;
        expire = 1'b0;
        if (wr_en) begin
            // a write beats a tick on the same edge
            slot_d.st  = wr_st;
            slot_d.cnt = (wr_op == OP_ADD) ? slot_q.cnt + wr_cnt : wr_cnt;
        end else if (tick && slot_q.st != '0 && slot_q.cnt != '0) begin
            slot_d.cnt = slot_q.cnt - 1'b1;
            if (slot_q.cnt == TMR_CNT_W'(1)) begin
                expire    = 1'b1;
                slot_d.st = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end
endmodule

// File: rtl/tmr_prio.sv
module tmr_prio #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);   // later (higher) index wins
        end
        any = |req;
    end
endmodule

// File: rtl/shared_timer_unit.sv
module shared_timer_unit
    import tmr_pkg::*;
#(
    parameter  int NUM_SLOTS = 16,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int CMD_W     = TMR_ST_W + TMR_CNT_W + IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic                 cmd_op,
    input  logic [CMD_W-1:0]     cmd_word,
    input  logic                 tick,
    input  logic                 wake_ack,
    input  logic [IDX_W-1:0]     rd_slot,
    output logic [TMR_ST_W-1:0]  rd_state,
    output logic [TMR_CNT_W-1:0] rd_count,
    output logic                 wake_req,
    output logic [IDX_W-1:0]     wake_slot
);
    // command field split: slot in the low bits, state in the high bits
    logic [IDX_W-1:0]     cmd_idx;
    logic [TMR_CNT_W-1:0] cmd_cnt;
    logic [TMR_ST_W-1:0]  cmd_st;
    assign cmd_idx = cmd_word[IDX_W-1:0];
    assign cmd_cnt = cmd_word[IDX_W +: TMR_CNT_W];
    assign cmd_st  = cmd_word[IDX_W+TMR_CNT_W +: TMR_ST_W];

    slot_t [NUM_SLOTS-1:0] slots_q;
    logic  [NUM_SLOTS-1:0] expire_vec;
    logic  [NUM_SLOTS-1:0] pend_d, pend_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        tmr_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .wr_en  (cmd_valid && (cmd_idx == IDX_W'(g))),
            .wr_op  (tmr_op_e'(cmd_op)),
            .wr_st  (cmd_st),
            .wr_cnt (cmd_cnt),
            .slot_q (slots_q[g]),
            .expire (expire_vec[g])
        );
    end

    tmr_prio #(.N(NUM_SLOTS)) u_prio (
        .req (pend_q),
        .any (wake_req),
        .idx (wake_slot)
    );

    always_comb begin
        pend_d = pend_q;
        if (wake_ack && wake_req) pend_d[wake_slot] = 1'b0;
        pend_d = pend_d | expire_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign rd_state = slots_q[rd_slot].st;
    assign rd_count = slots_q[rd_slot].cnt;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int IDX_W     = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  cmd_valid,
    input logic [IDX_W-1:0]      cmd_idx,
    input logic                  wake_req,
    input logic                  wake_ack,
    input logic [IDX_W-1:0]      wake_slot,
    input logic [NUM_SLOTS-1:0]  pend_q,
    input slot_t [NUM_SLOTS-1:0] slots_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!wake_req && slots_q == '0));

    assert_no_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (!wake_req && !tick) |=> !wake_req);

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (wake_req && wake_ack && !tick) |=> !pend_q[$past(wake_slot)]);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        assert_tick_dec_R4: assert property (@(posedge clk) disable iff (rst)
            (tick && !(cmd_valid && cmd_idx == IDX_W'(i))
             && slots_q[i].st != '0 && slots_q[i].cnt != '0)
            |=> slots_q[i].cnt == TMR_CNT_W'($past(slots_q[i].cnt) - 1'b1));

        assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
            ((!tick || slots_q[i].st == '0) && !(cmd_valid && cmd_idx == IDX_W'(i)))
            |=> $stable(slots_q[i]));

        assert_expire_idle_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_q[i]) |-> slots_q[i].st == '0);
    end
endmodule

bind shared_timer_unit tmr_unit_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_idx   (cmd_idx),
    .wake_req  (wake_req),
    .wake_ack  (wake_ack),
    .wake_slot (wake_slot),
    .pend_q    (pend_q),
    .slots_q   (slots_q)
);

// File: tb/shared_timer_unit_tb.sv
`timescale 1ns/1ps
module shared_timer_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        tick = 1'b0;
    logic        wake_ack = 1'b0;
    logic [3:0]  rd_slot = '0;
    logic [3:0]  rd_state;
    logic [7:0]  rd_count;
    logic        wake_req;
    logic [3:0]  wake_slot;

    int m_cnt [16];
    int m_st  [16];
    bit m_pend[16];
    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    shared_timer_unit u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .tick(tick), .wake_ack(wake_ack),
        .rd_slot(rd_slot), .rd_state(rd_state), .rd_count(rd_count),
        .wake_req(wake_req), .wake_slot(wake_slot)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [15:0] mk(int st, int cnt, int slot);
        logic [3:0] s4 = st[3:0];
        logic [7:0] c8 = cnt[7:0];
        logic [3:0] i4 = slot[3:0];
        return {s4, c8, i4};
    endfunction

    function automatic int top_pend();
        for (int i = 15; i >= 0; i--) if (m_pend[i]) return i;
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(bit r, bit v, bit op, logic [15:0] w, bit t, bit a);
        int rep;
        bit ex[16];
        if (r) begin
            for (int i = 0; i < 16; i++) begin
                m_cnt[i] = 0; m_st[i] = 0; m_pend[i] = 0;
            end
            return;
        end
        rep = top_pend();
        for (int i = 0; i < 16; i++) begin
            ex[i] = 0;
            if (v && int'(w[3:0]) == i) begin
                m_st[i]  = int'(w[15:12]);
                m_cnt[i] = op ? (m_cnt[i] + int'(w[11:4])) % 256 : int'(w[11:4]);
            end else if (t && m_st[i] != 0 && m_cnt[i] != 0) begin
                m_cnt[i]--;
                if (m_cnt[i] == 0) begin
                    m_st[i] = 0;
                    ex[i]   = 1;
                end
            end
        end
        if (a && rep >= 0) m_pend[rep] = 0;
        for (int i = 0; i < 16; i++) if (ex[i]) m_pend[i] = 1;
    endtask

    task automatic cycle(bit r, bit v, bit op, logic [15:0] w, bit t, bit a);
        @(negedge clk);
        rst = r; cmd_valid = v; cmd_op = op; cmd_word = w; tick = t; wake_ack = a;
        @(posedge clk);
        model_edge(r, v, op, w, t, a);
        @(negedge clk);
        rst = 0; cmd_valid = 0; cmd_op = 0; cmd_word = '0; tick = 0; wake_ack = 0;
        chk(wake_req == (top_pend() >= 0), "R5", int'(wake_req), int'(top_pend() >= 0));
        if (top_pend() >= 0)
            chk(int'(wake_slot) == top_pend(), "R6", int'(wake_slot), top_pend());
    endtask

    task automatic peek(int s, string tag);
        rd_slot = s[3:0];
        #0.2;
        chk(int'(rd_count) == m_cnt[s], tag, int'(rd_count), m_cnt[s]);
        chk(int'(rd_state) == m_st[s], tag, int'(rd_state), m_st[s]);
    endtask

    task automatic sweep(string tag);
        for (int s = 0; s < 16; s++) peek(s, tag);
    endtask

    task automatic cmd(bit op, int slot, int cnt, int st);
        cycle(0, 1, op, mk(st, cnt, slot), 0, 0);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) cycle(0, 0, 0, '0, 1, 0);
    endtask

    task automatic ack();
        cycle(0, 0, 0, '0, 0, 1);
    endtask

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset, after dirtying some slots
        cycle(1, 0, 0, '0, 0, 0);
        cmd(0, 7, 33, 2);
        cycle(1, 0, 0, '0, 0, 0);
        sweep("R1");
        chk(wake_req == 1'b0, "R1", int'(wake_req), 0);

        // R2: overwrite
        cmd(0, 3, 10, 5);
        peek(3, "R2");
        chk(rd_count == 8'd10 && rd_state == 4'd5, "R2", int'(rd_count), 10);
        // R3: accumulate and wrap
        cmd(1, 3, 7, 6);
        peek(3, "R3");
        chk(rd_count == 8'd17 && rd_state == 4'd6, "R3", int'(rd_count), 17);
        cmd(1, 3, 250, 6);
        peek(3, "R3");
        chk(rd_count == 8'd11, "R3", int'(rd_count), 11);

        // R4: decrement of active slot, idle slot holds
        cmd(0, 8, 40, 0);
        ticks(3);
        peek(3, "R4");
        chk(rd_count == 8'd8, "R4", int'(rd_count), 8);
        peek(8, "R4");
        chk(rd_count == 8'd40, "R4", int'(rd_count), 40);

        // R5/R6/R7: simultaneous expiry of slots 2, 9, 15
        cycle(1, 0, 0, '0, 0, 0);
        cmd(0, 2, 2, 1);
        cmd(0, 9, 2, 3);
        cmd(0, 15, 2, 1);
        ticks(1);
        chk(wake_req == 1'b0, "R5", int'(wake_req), 0);
        ticks(1);
        chk(wake_req == 1'b1, "R5", int'(wake_req), 1);
        peek(9, "R5");
        chk(rd_state == 4'd0 && rd_count == 8'd0, "R5", int'(rd_state), 0);
        chk(wake_slot == 4'd15, "R6", int'(wake_slot), 15);
        ack();
        chk(wake_req == 1'b1 && wake_slot == 4'd9, "R7", int'(wake_slot), 9);
        ack();
        chk(wake_req == 1'b1 && wake_slot == 4'd2, "R7", int'(wake_slot), 2);
        ack();
        chk(wake_req == 1'b0, "R7", int'(wake_req), 0);

        // R11: acknowledge with nothing pending
        cmd(0, 5, 4, 2);
        ack();
        chk(wake_req == 1'b0, "R11", int'(wake_req), 0);
        sweep("R11");

        // R9: expired refresh slot stays quiet, re-arm by accumulate
        ticks(4);
        peek(15, "R9");
        chk(rd_count == 8'd0 && rd_state == 4'd0, "R9", int'(rd_count), 0);
        chk(wake_slot == 4'd5, "R9", int'(wake_slot), 5);
        ack();
        cmd(1, 15, 3, 1);
        peek(15, "R9");
        chk(rd_count == 8'd3, "R9", int'(rd_count), 3);
        ticks(2);
        chk(wake_req == 1'b0, "R9", int'(wake_req), 0);
        ticks(1);
        chk(wake_req == 1'b1 && wake_slot == 4'd15, "R9", int'(wake_slot), 15);
        ack();

        // R8: command and tick on the same edge
        cmd(0, 4, 5, 2);
        cmd(0, 6, 1, 2);
        cycle(0, 1, 0, mk(2, 9, 4), 1, 0);
        peek(4, "R8");
        chk(rd_count == 8'd9, "R8", int'(rd_count), 9);
        peek(6, "R8");
        chk(rd_count == 8'd0 && wake_req == 1'b1, "R8", int'(rd_count), 0);
        ack();
        cmd(0, 6, 1, 2);
        cycle(0, 1, 1, mk(3, 4, 6), 1, 0);
        peek(6, "R8");
        chk(rd_count == 8'd5 && wake_req == 1'b0, "R8", int'(rd_count), 5);

        // R10: nonzero state with zero count
        cycle(1, 0, 0, '0, 0, 0);
        cmd(0, 11, 0, 7);
        ticks(3);
        peek(11, "R10");
        chk(rd_state == 4'd7 && rd_count == 8'd0, "R10", int'(rd_state), 7);
        chk(wake_req == 1'b0, "R10", int'(wake_req), 0);

        // mixed traffic against the reference model
        for (int k = 0; k < 2000; k++) begin
            bit v = ($urandom % 10) < 3;
            bit op = $urandom % 2;
            bit t = ($urandom % 2) == 1;
            bit a = ($urandom % 10) < 3;
            int s = $urandom % 16;
            cycle(0, v, op, mk($urandom % 16, $urandom % 6, s), t, a);
            if (k % 8 == 0) sweep("R4");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule